// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Compare Match

This block is an 8-bit up-counter peripheral that sits on a simple register bus. Each count step comes from a timer tick. A 3-bit clock-select field picks the tick source:

- the system clock, through a free-running prescaler, or
- a chosen edge of an external pin, brought into the clock domain by a two-flop synchronizer.

The pin is sampled whatever drives it. Software can therefore make the counter step by toggling the pin itself.

A compare register is checked against the count on every tick. When a tick arrives while the count equals the compare value, three things happen: the compare flag is set, the compare output toggles, and an interrupt request can follow. When a tick moves the count from 0xFF to 0x00, the overflow flag is set. Each flag has its own enable bit, and a global interrupt-enable input gates both requests.

A software write to the count suppresses the compare match on the next tick. This avoids a spurious match when software loads the count with the compare value.

Top module: `tmr8_top`

## Requirements
- R1: After reset, every register reads 0: count, compare, mask, flags and control. The compare output and both interrupt requests are 0.
- R2: The bus address map is: 0 = count, 1 = compare, 2 = mask, 3 = flags, 4 = control (clock select in bits 2:0). A write takes effect at the clock edge where bus_en and bus_we are high, and rdata shows the register selected by bus_addr. Mask bit 7 enables the compare interrupt and mask bit 6 enables the overflow interrupt. Flag bit 7 is the compare flag and flag bit 6 is the overflow flag. All other mask, flag and control bits read 0.
- R3: With clock select 000, the count never changes except through a bus write.
- R4: Clock-select codes 001, 010, 011, 100 and 101 give one tick per 1, 8, 64, 256 and 1024 system clocks. The tick comes from a 10-bit prescaler that runs freely from reset, and it fires when the low bits of the prescaler are all ones. Any window of N consecutive clocks with N a multiple of the divisor therefore holds exactly N/divisor ticks.
- R5: Code 111 counts rising edges of ext_pin and code 110 counts falling edges. Edges of the other polarity are not counted. A pin change made before clock edge k shows in the count after edge k+2.
- R6: A tick that arrives while count equals compare, and is not blocked, is a compare match. It sets the compare flag at that edge and toggles cmp_out.
- R7: A bus write to the count blocks the compare match on the next tick after the write.
- R8: A tick with count 0xFF wraps the count to 0x00 and sets the overflow flag.
- R9: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R10: irq_cmp is 1 exactly when the compare flag, mask bit 7 and glb_ie are all 1. irq_ovf is 1 exactly when the overflow flag, mask bit 6 and glb_ie are all 1.
- R11: When a bus write to the count and a tick fall in the same cycle, the written value is loaded, without increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ext_pin | input | 1 | External count source |
| glb_ie | input | 1 | Global interrupt enable |
| cmp_out | output | 1 | Output that toggles on each compare match |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 10-bit prescaler. At these sizes every compare value, all 256 of them, can be swept, with the count placed two ticks below the compare value each time. This sweep exercises the match timing across the whole range, and it exercises the four cases where the overflow wrap lands inside the window. The 10-bit prescaler keeps the slowest divisor short enough that every division code is run over four complete periods. The two enables and the global enable are tried in all combinations.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam logic [2:0] ADR_COUNT = 3'd0;
  localparam logic [2:0] ADR_CMP   = 3'd1;
  localparam logic [2:0] ADR_MASK  = 3'd2;
  localparam logic [2:0] ADR_FLAG  = 3'd3;
  localparam logic [2:0] ADR_CTRL  = 3'd4;

  // log2 of the prescaler divisor for a clock-select code
  function automatic int unsigned div_shift(clk_sel_e sel);
    case (sel)
      CS_DIV8:    return 3;
      CS_DIV64:   return 6;
      CS_DIV256:  return 8;
      CS_DIV1024: return 10;
      default:    return 0;
    endcase
  endfunction

  // Tick when the low 'sh' prescaler bits are all ones
  function automatic logic pre_tick(logic [15:0] pre, int unsigned sh);
    logic [15:0] m;
    m = 16'((32'd1 << sh) - 32'd1);
    return (pre & m) == m;
  endfunction

endpackage

// File: rtl/tmr8_tick_gen.sv
module tmr8_tick_gen
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e cs,
  input  logic     ext_pin,
  output logic     tick
);

  logic [PRE_W-1:0] pre;
  logic             sync1, sync2, prev;
  logic             ext_rise, ext_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= ext_pin;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign ext_rise = sync2 & ~prev;
  assign ext_fall = ~sync2 & prev;

  always_comb begin
    case (cs)
      CS_STOP:     tick = 1'b0;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = pre_tick(16'(pre), div_shift(cs));
    endcase
  end

  AST_EXT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs[2:1] == 2'b11 && tick) |=> (!tick || cs != $past(cs))); // R5

endmodule

// File: rtl/tmr8_count_core.sv
module tmr8_count_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic          cmp_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] cmp,
  output logic          match_evt,
  output logic          ovf_evt,
  output logic          cmp_out
);

  localparam logic [DW-1:0] CNT_MAX = '1;

  logic blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= wdata;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      blk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp <= '0;
    else if (cmp_wr) cmp <= wdata;
  end

  assign match_evt = tick & ~cnt_wr & ~blk & (cnt == cmp);
  assign ovf_evt   = tick & ~cnt_wr & (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)         cmp_out <= 1'b0;
    else if (match_evt) cmp_out <= ~cmp_out;
  end

  AST_MATCH_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (cmp_out != $past(cmp_out))); // R6
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !match_evt); // R7
  AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata))); // R11

endmodule

// File: rtl/tmr8_irq_regs.sv
module tmr8_irq_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic       flag_wr,
  input  logic [1:0] wd_hi,
  input  logic       match_evt,
  input  logic       ovf_evt,
  input  logic       glb_ie,
  output logic [1:0] mask_q,
  output logic [1:0] flag_q,
  output logic       irq_cmp,
  output logic       irq_ovf
);

  logic [1:0] clr;
  logic [1:0] set;

  assign clr = flag_wr ? wd_hi : 2'b00;
  assign set = {match_evt, ovf_evt};

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= 2'b00;
    else if (mask_wr) mask_q <= wd_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 2'b00;
    else        flag_q <= set | (flag_q & ~clr);
  end

  assign irq_cmp = flag_q[1] & mask_q[1] & glb_ie;
  assign irq_ovf = flag_q[0] & mask_q[0] & glb_ie;

  AST_CMP_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(match_evt)); // R6
  AST_OVF_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(ovf_evt)); // R8
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !wd_hi[1] && flag_q[1]) |=> flag_q[1]); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp || irq_ovf) |-> glb_ie); // R10

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
  import tmr8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_pin,
  input  logic          glb_ie,
  output logic          cmp_out,
  output logic          irq_cmp,
  output logic          irq_ovf
);

  localparam int LOW_W = DW - 2;

  logic          wr;
  logic          cnt_wr, cmp_wr, mask_wr, flag_wr, ctrl_wr;
  clk_sel_e      cs;
  logic          tick;
  logic [DW-1:0] cnt, cmp;
  logic          match_evt, ovf_evt;
  logic [1:0]    mask_q, flag_q;

  assign wr      = bus_en & bus_we;
  assign cnt_wr  = wr & (bus_addr == ADR_COUNT);
  assign cmp_wr  = wr & (bus_addr == ADR_CMP);
  assign mask_wr = wr & (bus_addr == ADR_MASK);
  assign flag_wr = wr & (bus_addr == ADR_FLAG);
  assign ctrl_wr = wr & (bus_addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)       cs <= CS_STOP;
    else if (ctrl_wr) cs <= clk_sel_e'(bus_wdata[2:0]);
  end

  tmr8_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .ext_pin (ext_pin),
    .tick    (tick)
  );

  tmr8_count_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cmp_wr    (cmp_wr),
    .wdata     (bus_wdata),
    .cnt       (cnt),
    .cmp       (cmp),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .cmp_out   (cmp_out)
  );

  tmr8_irq_regs u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .flag_wr   (flag_wr),
    .wd_hi     (bus_wdata[DW-1:DW-2]),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .glb_ie    (glb_ie),
    .mask_q    (mask_q),
    .flag_q    (flag_q),
    .irq_cmp   (irq_cmp),
    .irq_ovf   (irq_ovf)
  );

  always_comb begin
    case (bus_addr)
      ADR_COUNT: bus_rdata = cnt;
      ADR_CMP:   bus_rdata = cmp;
      ADR_MASK:  bus_rdata = {mask_q, {LOW_W{1'b0}}};
      ADR_FLAG:  bus_rdata = {flag_q, {LOW_W{1'b0}}};
      ADR_CTRL:  bus_rdata = DW'(cs);
      default:   bus_rdata = '0;
    endcase
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == CS_STOP && !cnt_wr) |=> $stable(cnt)); // R3
  AST_CS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cs == clk_sel_e'($past(bus_wdata[2:0])))); // R2

endmodule

// File: tb/tmr8_top_test.sv
`timescale 1ns/1ps
module tmr8_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0, glb_ie = 1'b0;
  logic       cmp_out, irq_cmp, irq_ovf;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  tmr8_top uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .glb_ie(glb_ie), .cmp_out(cmp_out),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // issued at a negedge; lands on the next posedge; returns at the negedge after
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, int'(v), exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic       exp_tog;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reset reg", 3'(a), 0);
    chk("R1 cmp_out", cmp_out, 0);
    chk("R1 irq", {irq_cmp, irq_ovf}, 0);

    // R2 read/write and unused bits
    wr(3'd1, 8'hA5); rd_chk("R2 compare", 3'd1, 8'hA5);
    wr(3'd2, 8'hFF); rd_chk("R2 mask bits", 3'd2, 8'hC0);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'hFE); rd_chk("R2 ctrl field", 3'd4, 8'h06);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h3C); rd_chk("R2 count", 3'd0, 8'h3C);

    // R3 stopped counter
    repeat (50) @(negedge clk);
    rd_chk("R3 stopped", 3'd0, 8'h3C);

    // R4 prescaler sweep: 4 full periods each
    for (int code = 1; code <= 5; code++) begin
      int sh, n;
      sh = (code == 1) ? 0 : (code == 2) ? 3 : (code == 3) ? 6 : (code == 4) ? 8 : 10;
      n  = 4 * (1 << sh);
      wr(3'd0, 8'h00);
      wr(3'd4, 8'(code));
      repeat (n - 1) @(negedge clk);
      wr(3'd4, 8'h00);
      rd_chk($sformatf("R4 divider code %0d", code), 3'd0, n >> sh);
    end

    // R6/R8 compare sweep over every value
    rd(3'd0, v);
    exp_tog = 1'b0;
    for (int c = 0; c < 256; c++) begin
      int ovf;
      ovf = 0;
      for (int k = -2; k <= 1; k++) if (((c + k) & 255) == 255) ovf = 1;
      wr(3'd3, 8'hC0);
      wr(3'd1, 8'(c));
      wr(3'd0, 8'((c - 2) & 255));
      wr(3'd4, 8'h01);
      @(negedge clk);
      @(negedge clk);
      rd(3'd3, v);
      chk($sformatf("R6 no early match c=%0d", c), int'(v[7]), 0);
      @(negedge clk);
      rd(3'd3, v);
      chk($sformatf("R6 match flag c=%0d", c), int'(v[7]), 1);
      exp_tog = ~exp_tog;
      wr(3'd4, 8'h00);
      rd(3'd3, v);
      chk($sformatf("R8 ovf flag c=%0d", c), int'(v[6]), ovf);
      rd_chk($sformatf("R8 count c=%0d", c), 3'd0, (c + 2) & 255);
      chk($sformatf("R6 cmp_out c=%0d", c), cmp_out, exp_tog);
    end

    // R7 write blocks next tick's match
    wr(3'd3, 8'hC0);
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h10);
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h00);
    rd_chk("R7 count after blocked tick", 3'd0, 8'h11);
    rd_chk("R7 flag blocked", 3'd3, 8'h00);
    chk("R7 cmp_out held", cmp_out, exp_tog);

    // R11 write during running tick, then R7 again
    wr(3'd0, 8'h0E);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h10);
    rd_chk("R11 write wins over tick", 3'd0, 8'h10);
    wr(3'd4, 8'h00);
    rd_chk("R7 running write blocked count", 3'd0, 8'h11);
    rd_chk("R7 running write blocked flag", 3'd3, 8'h00);

    // R5 rising edges
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h07);
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1'b1; repeat (4) @(negedge clk);
      ext_pin = 1'b0; repeat (4) @(negedge clk);
    end
    rd_chk("R5 five rises", 3'd0, 5);
    ext_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_chk("R5 latency two edges", 3'd0, 5);
    @(negedge clk);
    rd_chk("R5 latency three edges", 3'd0, 6);
    ext_pin = 1'b0; repeat (5) @(negedge clk);
    rd_chk("R5 fall ignored in rise mode", 3'd0, 6);
    wr(3'd4, 8'h00);

    // R5 falling edges
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h06);
    for (int i = 0; i < 3; i++) begin
      ext_pin = 1'b1; repeat (4) @(negedge clk);
      if (i == 0) rd_chk("R5 rise ignored in fall mode", 3'd0, 0);
      ext_pin = 1'b0; repeat (4) @(negedge clk);
    end
    wr(3'd4, 8'h00);
    rd_chk("R5 three falls", 3'd0, 3);

    // set both flags: FE -> FF -> wrap with compare at FF
    wr(3'd3, 8'hC0);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFE);
    wr(3'd4, 8'h01);
    @(negedge clk);
    wr(3'd4, 8'h00);
    rd_chk("R8 both flags set", 3'd3, 8'hC0);

    // R10 all mask and enable combinations
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        wr(3'd2, 8'(m << 6));
        glb_ie = 1'(g);
        #1;
        chk($sformatf("R10 irq_cmp m=%0d g=%0d", m, g), irq_cmp, (m >> 1) & g);
        chk($sformatf("R10 irq_ovf m=%0d g=%0d", m, g), irq_ovf, m & 1 & g);
      end
    end

    // R9 write-one-to-clear
    wr(3'd3, 8'h00); rd_chk("R9 zero keeps", 3'd3, 8'hC0);
    wr(3'd3, 8'h80); rd_chk("R9 clear cmp", 3'd3, 8'h40);
    chk("R10 irq_cmp drops", irq_cmp, 0);
    wr(3'd3, 8'h40); rd_chk("R9 clear ovf", 3'd3, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule